// File: doc/BRIEF.md
# IOMMU Fault Status and Interrupt Unit

This unit sits beside the address-translation walker and the access-permission
checker of an I/O memory-management unit. It receives three kinds of fault
event: an invalid first-level table entry, an invalid second-level table entry,
and a permission violation raised on behalf of one bus master. Every event
carries the faulting address and the index of the master that issued the
access. A permission event also carries the page entry that refused it.

For every event the unit raises a sticky status bit and keeps the context of
the first occurrence. For a permission fault this context is the address and
the page entry, held per master. For a table fault it is the address and a
one-hot word naming the master. Software reads this context through a simple
register port. It acknowledges faults by writing a bit mask to a clear register.
A level interrupt is asserted while any status bit is set whose enable bit is
also set.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, every status bit, every enable bit and every capture register read 0, and `irq` is low.
- R2: A permission event for master m (m < NUM_MASTERS) sets status bit m. An event of any kind whose master index is NUM_MASTERS or more changes no status bit and no capture register.
- R3: An invalid first-level event sets status bit 16. An invalid second-level event sets status bit 17. The status register is read at offset 0x108.
- R4: A permission event for master m stores its address at offset 0x110 + 4*m and its page entry at offset 0x150 + 4*m.
- R5: An invalid first-level event stores its address at 0x130 and a blame word at 0x180. An invalid second-level event stores its address at 0x134 and a blame word at 0x184. The blame word has only bit m set for master m.
- R6: A capture register loads only when its status bit is clear. While the bit stays set, later faults of the same source leave the stored context unchanged.
- R7: A write to offset 0x104 clears the status bits that are set in the written mask, using the same bit positions as the status register. Reads of 0x104 return 0.
- R8: If a fault and a clear of its status bit arrive in the same cycle, the status bit stays set and the capture register takes the new fault.
- R9: `irq` is high exactly when some status bit is set whose enable bit is also set. The enable register is read and written at 0x100. Only bits 0..NUM_MASTERS-1, 16 and 17 are writable, and all other bits read 0.
- R10: Writes to the status register at 0x108 have no effect.
- R11: Reads of an offset with no register behind it return 0. This includes the per-master slots for masters at index NUM_MASTERS and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| l1_flt_vld | input | 1 | Invalid first-level entry event |
| l1_flt_mst | input | MST_W | Master index of the first-level event |
| l1_flt_addr | input | ADDR_W | Faulting address of the first-level event |
| l2_flt_vld | input | 1 | Invalid second-level entry event |
| l2_flt_mst | input | MST_W | Master index of the second-level event |
| l2_flt_addr | input | ADDR_W | Faulting address of the second-level event |
| perm_flt_vld | input | 1 | Permission violation event |
| perm_flt_mst | input | MST_W | Master index of the permission event |
| perm_flt_addr | input | ADDR_W | Faulting address of the permission event |
| perm_flt_entry | input | ENTRY_W | Page entry that refused the access |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its defaults: six masters, a 3-bit master index,
and 32-bit addresses and entries. With a 3-bit index the bench can also issue
master indices 6 and 7, so out-of-range events can be driven at the ports. The
read slots at 0x128 and 0x168 have no register behind them, so reads there must
return 0. Full-width addresses and entries make a dropped or shifted bit visible
in every readback.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int REG_AW  = 12;
    localparam int REG_DW  = 32;
    localparam int MAX_MST = 8;

    localparam logic [REG_AW-1:0] OFS_ENABLE     = 12'h100;
    localparam logic [REG_AW-1:0] OFS_CLEAR      = 12'h104;
    localparam logic [REG_AW-1:0] OFS_STATUS     = 12'h108;
    localparam logic [REG_AW-1:0] OFS_PADDR_BASE = 12'h110;
    localparam logic [REG_AW-1:0] OFS_L1_ADDR    = 12'h130;
    localparam logic [REG_AW-1:0] OFS_L2_ADDR    = 12'h134;
    localparam logic [REG_AW-1:0] OFS_PDATA_BASE = 12'h150;
    localparam logic [REG_AW-1:0] OFS_L1_BLAME   = 12'h180;
    localparam logic [REG_AW-1:0] OFS_L2_BLAME   = 12'h184;

    localparam int BIT_L1 = 16;
    localparam int BIT_L2 = 17;

endpackage

// File: rtl/fsu_mst_decode.sv
module fsu_mst_decode #(
    parameter int NM = 6,
    parameter int MW = 3
) (
    input  logic          vld,
    input  logic [MW-1:0] idx,
    output logic [NM-1:0] onehot
);

    always_comb begin
        onehot = '0;
        for (int i = 0; i < NM; i++) begin
            onehot[i] = vld && (idx == MW'(i));
        end
    end

endmodule

// File: rtl/fsu_capture.sv
module fsu_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] rec;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.rec = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign dout = cap_q.rec;

endmodule

// File: rtl/fsu_status.sv
module fsu_status #(
    parameter int NM = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] perm_hit,
    input  logic          l1_hit,
    input  logic          l2_hit,
    input  logic          en_wr,
    input  logic          clr_wr,
    input  logic [NM-1:0] wr_perm_bits,
    input  logic          wr_l1,
    input  logic          wr_l2,
    output logic [NM-1:0] sts_perm,
    output logic          sts_l1,
    output logic          sts_l2,
    output logic [NM-1:0] en_perm,
    output logic          en_l1,
    output logic          en_l2,
    output logic [NM-1:0] cap_perm,
    output logic          cap_l1,
    output logic          cap_l2,
    output logic          irq
);

    typedef struct packed {
        logic [NM-1:0] perm;
        logic          l1;
        logic          l2;
        logic [NM-1:0] en_perm;
        logic          en_l1;
        logic          en_l2;
        logic          irq;
    } st_t;

    st_t st_d, st_q;

    logic [NM-1:0] clr_perm;
    logic          clr_l1;
    logic          clr_l2;

    always_comb begin
        st_d     = st_q;
        clr_perm = clr_wr ? wr_perm_bits : '0;
        clr_l1   = clr_wr && wr_l1;
        clr_l2   = clr_wr && wr_l2;

        // a source captures when its bit is free now or is freed this cycle
        cap_perm = perm_hit & (~st_q.perm | clr_perm);
        cap_l1   = l1_hit && (!st_q.l1 || clr_l1);
        cap_l2   = l2_hit && (!st_q.l2 || clr_l2);

        // set has priority over clear
        st_d.perm = (st_q.perm & ~clr_perm) | perm_hit;
        st_d.l1   = (st_q.l1 && !clr_l1) || l1_hit;
        st_d.l2   = (st_q.l2 && !clr_l2) || l2_hit;

        if (en_wr) begin
            st_d.en_perm = wr_perm_bits;
            st_d.en_l1   = wr_l1;
            st_d.en_l2   = wr_l2;
        end

        st_d.irq = (|(st_d.perm & st_d.en_perm))
                 || (st_d.l1 && st_d.en_l1)
                 || (st_d.l2 && st_d.en_l2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_perm = st_q.perm;
    assign sts_l1   = st_q.l1;
    assign sts_l2   = st_q.l2;
    assign en_perm  = st_q.en_perm;
    assign en_l1    = st_q.en_l1;
    assign en_l2    = st_q.en_l2;
    assign irq      = st_q.irq;

    for (genvar m = 0; m < NM; m++) begin : g_ast
        AST_PERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
            perm_hit[m] |=> sts_perm[m]);                               // R2
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wr_perm_bits[m] && !perm_hit[m]) |=> !sts_perm[m]); // R7
    end

    AST_L1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        l1_hit |=> sts_l1);                                             // R3
    AST_L2_SET: assert property (@(posedge clk) disable iff (!rst_n)
        l2_hit |=> sts_l2);                                             // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && wr_perm_bits == '0 && !wr_l1 && !wr_l2) |=> !irq);    // R9

endmodule

// File: rtl/fsu_rdmux.sv
module fsu_rdmux
    import fsu_pkg::*;
#(
    parameter int NM = 6,
    parameter int AW = 32,
    parameter int EW = 32
) (
    input  logic [REG_AW-1:0]     addr,
    input  logic [NM-1:0]         sts_perm,
    input  logic                  sts_l1,
    input  logic                  sts_l2,
    input  logic [NM-1:0]         en_perm,
    input  logic                  en_l1,
    input  logic                  en_l2,
    input  logic [NM-1:0][AW-1:0] perm_addr,
    input  logic [NM-1:0][EW-1:0] perm_entry,
    input  logic [AW-1:0]         l1_addr,
    input  logic [NM-1:0]         l1_blame,
    input  logic [AW-1:0]         l2_addr,
    input  logic [NM-1:0]         l2_blame,
    output logic [REG_DW-1:0]     rdata
);

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_ENABLE: begin
                rdata[NM-1:0] = en_perm;
                rdata[BIT_L1] = en_l1;
                rdata[BIT_L2] = en_l2;
            end
            OFS_STATUS: begin
                rdata[NM-1:0] = sts_perm;
                rdata[BIT_L1] = sts_l1;
                rdata[BIT_L2] = sts_l2;
            end
            OFS_L1_ADDR:  rdata[AW-1:0] = l1_addr;
            OFS_L2_ADDR:  rdata[AW-1:0] = l2_addr;
            OFS_L1_BLAME: rdata[NM-1:0] = l1_blame;
            OFS_L2_BLAME: rdata[NM-1:0] = l2_blame;
            default: begin
                for (int m = 0; m < NM; m++) begin
                    if (addr == REG_AW'(OFS_PADDR_BASE + 4 * m)) begin
                        rdata[AW-1:0] = perm_addr[m];
                    end
                    if (addr == REG_AW'(OFS_PDATA_BASE + 4 * m)) begin
                        rdata[EW-1:0] = perm_entry[m];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
    import fsu_pkg::*;
#(
    parameter int NUM_MASTERS = 6,
    parameter int MST_W       = 3,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               l1_flt_vld,
    input  logic [MST_W-1:0]   l1_flt_mst,
    input  logic [ADDR_W-1:0]  l1_flt_addr,
    input  logic               l2_flt_vld,
    input  logic [MST_W-1:0]   l2_flt_mst,
    input  logic [ADDR_W-1:0]  l2_flt_addr,
    input  logic               perm_flt_vld,
    input  logic [MST_W-1:0]   perm_flt_mst,
    input  logic [ADDR_W-1:0]  perm_flt_addr,
    input  logic [ENTRY_W-1:0] perm_flt_entry,
    output logic               irq
);

    localparam int NM     = NUM_MASTERS;
    localparam int PREC_W = ADDR_W + ENTRY_W;
    localparam int TREC_W = ADDR_W + NM;

    logic [NM-1:0] perm_oh, l1_oh, l2_oh;
    logic          en_wr, clr_wr;
    logic [NM-1:0] sts_perm, en_perm, cap_perm;
    logic          sts_l1, sts_l2, en_l1, en_l2, cap_l1, cap_l2;
    logic          wdata_unused;

    logic [NM-1:0][PREC_W-1:0]  perm_rec;
    logic [NM-1:0][ADDR_W-1:0]  perm_addr;
    logic [NM-1:0][ENTRY_W-1:0] perm_entry;
    logic [TREC_W-1:0]          l1_rec, l2_rec;

    assign en_wr        = reg_wr && (reg_addr == OFS_ENABLE);
    assign clr_wr       = reg_wr && (reg_addr == OFS_CLEAR);
    assign wdata_unused = ^{reg_wdata[31:BIT_L2+1], reg_wdata[BIT_L1-1:NM]};

    fsu_mst_decode #(.NM(NM), .MW(MST_W)) u_dec_perm (
        .vld(perm_flt_vld), .idx(perm_flt_mst), .onehot(perm_oh));
    fsu_mst_decode #(.NM(NM), .MW(MST_W)) u_dec_l1 (
        .vld(l1_flt_vld), .idx(l1_flt_mst), .onehot(l1_oh));
    fsu_mst_decode #(.NM(NM), .MW(MST_W)) u_dec_l2 (
        .vld(l2_flt_vld), .idx(l2_flt_mst), .onehot(l2_oh));

    fsu_status #(.NM(NM)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .perm_hit     (perm_oh),
        .l1_hit       (|l1_oh),
        .l2_hit       (|l2_oh),
        .en_wr        (en_wr),
        .clr_wr       (clr_wr),
        .wr_perm_bits (reg_wdata[NM-1:0]),
        .wr_l1        (reg_wdata[BIT_L1]),
        .wr_l2        (reg_wdata[BIT_L2]),
        .sts_perm     (sts_perm),
        .sts_l1       (sts_l1),
        .sts_l2       (sts_l2),
        .en_perm      (en_perm),
        .en_l1        (en_l1),
        .en_l2        (en_l2),
        .cap_perm     (cap_perm),
        .cap_l1       (cap_l1),
        .cap_l2       (cap_l2),
        .irq          (irq)
    );

    for (genvar m = 0; m < NM; m++) begin : g_perm
        fsu_capture #(.W(PREC_W)) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .load (cap_perm[m]),
            .din  ({perm_flt_addr, perm_flt_entry}),
            .dout (perm_rec[m])
        );
        assign perm_addr[m]  = perm_rec[m][PREC_W-1:ENTRY_W];
        assign perm_entry[m] = perm_rec[m][ENTRY_W-1:0];

        AST_PERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_perm[m] && !(clr_wr && reg_wdata[m])) |=> $stable(perm_rec[m])); // R6
    end

    fsu_capture #(.W(TREC_W)) u_cap_l1 (
        .clk(clk), .rst_n(rst_n), .load(cap_l1),
        .din({l1_flt_addr, l1_oh}), .dout(l1_rec));
    fsu_capture #(.W(TREC_W)) u_cap_l2 (
        .clk(clk), .rst_n(rst_n), .load(cap_l2),
        .din({l2_flt_addr, l2_oh}), .dout(l2_rec));

    fsu_rdmux #(.NM(NM), .AW(ADDR_W), .EW(ENTRY_W)) u_rdmux (
        .addr      (reg_addr),
        .sts_perm  (sts_perm),
        .sts_l1    (sts_l1),
        .sts_l2    (sts_l2),
        .en_perm   (en_perm),
        .en_l1     (en_l1),
        .en_l2     (en_l2),
        .perm_addr (perm_addr),
        .perm_entry(perm_entry),
        .l1_addr   (l1_rec[TREC_W-1:NM]),
        .l1_blame  (l1_rec[NM-1:0]),
        .l2_addr   (l2_rec[TREC_W-1:NM]),
        .l2_blame  (l2_rec[NM-1:0]),
        .rdata     (reg_rdata)
    );

    AST_L1_BLAME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l1_rec[NM-1:0]));                                        // R5
    AST_L2_BLAME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l2_rec[NM-1:0]));                                        // R5
    AST_L1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_l1 && !(clr_wr && reg_wdata[BIT_L1])) |=> $stable(l1_rec));  // R6
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_l1 || sts_l2 || (|sts_perm)));                       // R9

endmodule

// File: tb/test_fault_status_unit.sv
`timescale 1ns/1ps
module test_fault_status_unit;

    localparam int A_EN = 'h100, A_CLR = 'h104, A_STS = 'h108;
    localparam int A_PA = 'h110, A_PD = 'h150;
    localparam int A_L1A = 'h130, A_L2A = 'h134, A_L1B = 'h180, A_L2B = 'h184;

    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        l1_flt_vld = 0, l2_flt_vld = 0, perm_flt_vld = 0;
    logic [2:0]  l1_flt_mst = '0, l2_flt_mst = '0, perm_flt_mst = '0;
    logic [31:0] l1_flt_addr = '0, l2_flt_addr = '0, perm_flt_addr = '0, perm_flt_entry = '0;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    fault_status_unit i_fault_status_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .l1_flt_vld(l1_flt_vld), .l1_flt_mst(l1_flt_mst), .l1_flt_addr(l1_flt_addr),
        .l2_flt_vld(l2_flt_vld), .l2_flt_mst(l2_flt_mst), .l2_flt_addr(l2_flt_addr),
        .perm_flt_vld(perm_flt_vld), .perm_flt_mst(perm_flt_mst),
        .perm_flt_addr(perm_flt_addr), .perm_flt_entry(perm_flt_entry), .irq(irq));

    // table: kind 0=permission 1=first level 2=second level
    localparam int NV = 5;
    localparam int          V_KIND [NV] = '{0, 1, 2, 0, 0};
    localparam logic [2:0]  V_MST  [NV] = '{3'd2, 3'd4, 3'd1, 3'd5, 3'd0};
    localparam logic [31:0] V_ADDR [NV] = '{32'h1234_5000, 32'h8000_0000, 32'h0040_1000,
                                           32'hFFFF_F000, 32'h0000_0004};
    localparam logic [31:0] V_ENT  [NV] = '{32'hABCD_E021, 32'h0, 32'h0, 32'h0000_0032, 32'h1};
    localparam logic [31:0] V_STS  [NV] = '{32'h4, 32'h1_0004, 32'h3_0004, 32'h3_0024, 32'h3_0025};
    localparam int          V_AOF  [NV] = '{A_PA + 8, A_L1A, A_L2A, A_PA + 20, A_PA};
    localparam int          V_SOF  [NV] = '{A_PD + 8, A_L1B, A_L2B, A_PD + 20, A_PD};
    localparam logic [31:0] V_SVAL [NV] = '{32'hABCD_E021, 32'h10, 32'h2, 32'h32, 32'h1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input int a, input logic [31:0] exp);
        reg_addr = 12'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic flt(input int kind, input logic [2:0] m, input logic [31:0] a, input logic [31:0] e);
        @(negedge clk);
        case (kind)
            0: begin perm_flt_vld = 1; perm_flt_mst = m; perm_flt_addr = a; perm_flt_entry = e; end
            1: begin l1_flt_vld = 1; l1_flt_mst = m; l1_flt_addr = a; end
            default: begin l2_flt_vld = 1; l2_flt_mst = m; l2_flt_addr = a; end
        endcase
        @(negedge clk);
        perm_flt_vld = 0; l1_flt_vld = 0; l2_flt_vld = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rdchk("R1 status", A_STS, 0);
        rdchk("R1 enable", A_EN, 0);
        rdchk("R1 perm addr", A_PA, 0);
        rdchk("R1 l1 addr", A_L1A, 0);
        rdchk("R1 l2 blame", A_L2B, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        wr(A_EN, 32'h3_003F);
        for (int v = 0; v < NV; v++) begin
            flt(V_KIND[v], V_MST[v], V_ADDR[v], V_ENT[v]);
            rdchk("R2/R3 status", A_STS, V_STS[v]);
            rdchk("R4/R5 address", V_AOF[v], V_ADDR[v]);
            rdchk("R4/R5 entry or blame", V_SOF[v], V_SVAL[v]);
            chk("R9 irq enabled", {31'b0, irq}, 1);
        end

        // R6 first fault kept
        flt(0, 3'd2, 32'h9999_9000, 32'h77);
        rdchk("R6 perm addr kept", A_PA + 8, 32'h1234_5000);
        rdchk("R6 perm entry kept", A_PD + 8, 32'hABCD_E021);
        flt(1, 3'd3, 32'h1, 0);
        rdchk("R6 l1 addr kept", A_L1A, 32'h8000_0000);
        rdchk("R6 l1 blame kept", A_L1B, 32'h10);

        // R10 status is read-only
        wr(A_STS, 0);
        rdchk("R10 status unchanged", A_STS, 32'h3_0025);

        // R7 clear
        wr(A_CLR, 32'h4);
        rdchk("R7 status after clear", A_STS, 32'h3_0021);
        rdchk("R7 clear reads zero", A_CLR, 0);
        flt(0, 3'd2, 32'h5555_5000, 32'h88);
        rdchk("R6 recapture after clear", A_PA + 8, 32'h5555_5000);

        // R8 clear and fault together
        @(negedge clk);
        reg_wr = 1; reg_addr = 12'(A_CLR); reg_wdata = 32'h20;
        perm_flt_vld = 1; perm_flt_mst = 3'd5; perm_flt_addr = 32'h6666_6000; perm_flt_entry = 32'h44;
        @(negedge clk);
        reg_wr = 0; perm_flt_vld = 0;
        rdchk("R8 status kept", A_STS, 32'h3_0025);
        rdchk("R8 new addr", A_PA + 20, 32'h6666_6000);
        rdchk("R8 new entry", A_PD + 20, 32'h44);

        // R2 out-of-range masters
        wr(A_CLR, 32'h3_003F);
        rdchk("R7 clear all", A_STS, 0);
        chk("R9 irq low no status", {31'b0, irq}, 0);
        flt(0, 3'd7, 32'hDEAD_0000, 32'h5);
        flt(1, 3'd6, 32'hBEEF_0000, 0);
        rdchk("R2 out-of-range ignored", A_STS, 0);
        rdchk("R2 l1 addr untouched", A_L1A, 32'h8000_0000);
        chk("R2 irq stays low", {31'b0, irq}, 0);

        // R9 enable mask
        wr(A_EN, 32'hFFFF_FFFF);
        rdchk("R9 enable writable bits", A_EN, 32'h3_003F);
        wr(A_EN, 32'h1_0000);
        flt(2, 3'd0, 32'h0000_3000, 0);
        rdchk("R3 l2 status", A_STS, 32'h2_0000);
        chk("R9 irq masked", {31'b0, irq}, 0);
        flt(1, 3'd0, 32'h0000_4000, 0);
        chk("R9 irq unmasked", {31'b0, irq}, 1);
        rdchk("R5 l1 blame master0", A_L1B, 32'h1);
        wr(A_EN, 0);
        chk("R9 irq after disable", {31'b0, irq}, 0);

        // R11 unmapped
        rdchk("R11 unmapped", 'h0FC, 0);
        rdchk("R11 slot beyond masters", A_PA + 24, 0);
        rdchk("R11 entry slot beyond masters", A_PD + 24, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule